// File: doc/BRIEF.md
# Dual 32-bit Register-Mapped Timer

This block is a timer peripheral with two independent counter halves, low and high, each 32 bits wide. Both halves run unchained. Software reaches it through a plain word-addressed register bus with a one-cycle registered read. Each half has a count word and a period word. A shared control word holds a 16-bit field group for each half: run mode, output shaping and interrupt enable. A global word holds a reset-release bit for each half, a stored timer-mode code, and a divide-down prescaler that paces the high half.

A half counts up from zero once per timer tick. When the count equals the period word, that is a period match: the count returns to zero, the half's event output fires and, if enabled, the half's interrupt pulses. A run of N ticks is therefore programmed as N-1. Ticks come from the core clock divided by a fixed divisor, and that divisor can be read back. One-shot mode stops itself after one match and leaves a status flag set. Continuous mode reloads and keeps going.

Top module: `dual_tmr32`

## Requirements
- R1: Word index = byte offset / 4. The word indices are: clock-speed 1, low count 4, high count 5, low period 6, high period 7, control 8, global 9, watchdog word 10. The indices 0, 2 and 3, and any unlisted index, read as zero. Read data appears on `bus_rdata` after the clock edge that takes the read. The clock-speed word holds the tick divisor in bits 19:16 and ignores writes.
- R2: Global bit 0 releases the low half and bit 1 releases the high half. While a release bit is 0, that half's count is held at zero and count writes to it have no effect.
- R3: Each half's run mode is control bits 7:6 (low) or 23:22 (high). The code 00 stops the half and keeps its count. The code 01 is one-shot. The code 10 is continuous.
- R4: A running half adds one to its count per tick. When the count equals the period word, the count returns to zero on that tick, so matches recur every period+1 ticks.
- R5: When a one-shot half reaches its match, the hardware sets its run mode to 00 and its status bit (bit 0 or bit 16) to 1. Any write to the control word clears both status bits.
- R6: A write to a count word loads that count on the write's clock edge, and the load takes priority over counting.
- R7: When interrupt enable (bit 9 or bit 25) is set, every period match produces a 1-cycle pulse on that half's interrupt output.
- R8: Event output shaping, per half. With the clock/pulse bit (bit 3 or 19) at 0, the output pulses for 2^w cycles, where w is the pulse-width field (bits 5:4 or 21:20). With that bit at 1, the output toggles on each match. Output invert (bit 1 or 17) inverts the level.
- R9: The high half counts only on ticks where its prescale counter is zero. The prescale counter is then reloaded from the divide-down field (global bits 15:12), so the high half counts once per div+1 ticks. The prescale counter reads back in global bits 11:8 and is loaded from those bits when the global word is written.
- R10: With the clock-source bit (bit 8 or 24) set, a half does not count.
- R11: Ticks occur once every CLK_DIV core clock cycles.
- R12: The timer-mode field (global bits 3:2) and the watchdog word store the written value and read it back. Neither changes counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_lo | output | 1 | Low half event output |
| evt_hi | output | 1 | High half event output |
| irq_lo | output | 1 | Low half interrupt pulse |
| irq_hi | output | 1 | High half interrupt pulse |

## Verification
The assertions check the following on every cycle:
- a held half stays at zero;
- a stopped low half keeps its count;
- a one-shot match clears the low half's run mode and sets its status bit;
- the high half stays put while its prescaler is nonzero;
- an interrupt appears only with its enable set;
- the clock-speed word reads back the divisor.

Only the bench scenarios can show the timing along the output waveforms: the spacing between matches, pulse length against the width field, toggle spacing, the exact count the high half reaches through the prescaler, and read-back of the stored fields.

// File: rtl/dt_pkg.sv
`timescale 1ns/1ps
package dt_pkg;
   // word indices on the register bus (byte offset / 4)
   localparam int unsigned A_CLKSPD = 1;
   localparam int unsigned A_CNT_LO = 4;
   localparam int unsigned A_CNT_HI = 5;
   localparam int unsigned A_PRD_LO = 6;
   localparam int unsigned A_PRD_HI = 7;
   localparam int unsigned A_CTL    = 8;
   localparam int unsigned A_GCTL   = 9;
   localparam int unsigned A_WDT    = 10;

   // run-mode codes
   localparam logic [1:0] MODE_OFF  = 2'b00;
   localparam logic [1:0] MODE_ONCE = 2'b01;
   localparam logic [1:0] MODE_CONT = 2'b10;

   // per-half control field group
   localparam int CTL_STRIDE = 16;
   localparam int CTL_USED   = 10;
   localparam int PSC_W      = 4;
endpackage

// File: rtl/dt_tick.sv
`timescale 1ns/1ps
module dt_tick #(
   parameter int DIV = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_every
         logic unused_tick;
         assign unused_tick = clk ^ rst_n;
         assign tick = 1'b1;
      end else begin : g_div
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] div_q;
         assign tick = (div_q == CW'(DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    div_q <= '0;
            else if (tick) div_q <= '0;
            else           div_q <= div_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/dt_prescale.sv
`timescale 1ns/1ps
module dt_prescale #(
   parameter int PW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          load,
   input  logic [PW-1:0] load_val,
   input  logic          adv,
   input  logic [PW-1:0] div,
   output logic [PW-1:0] cnt,
   output logic          fire
);
   logic [PW-1:0] cnt_q;
   assign cnt  = cnt_q;
   assign fire = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (clr)  cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (adv)  cnt_q <= fire ? div : cnt_q - 1'b1;
   end
endmodule

// File: rtl/dt_half.sv
`timescale 1ns/1ps
module dt_half
   import dt_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter bit HAS_PSC = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                rel,
   input  logic                we_cnt,
   input  logic                we_prd,
   input  logic                we_ctl,
   input  logic [CNT_W-1:0]    wdata,
   input  logic [CTL_USED-1:0] ctl_wdata,
   input  logic                we_psc,
   input  logic [PSC_W-1:0]    psc_wval,
   input  logic [PSC_W-1:0]    psc_div,
   output logic [CNT_W-1:0]    cnt,
   output logic [CNT_W-1:0]    prd,
   output logic [CTL_USED-1:0] ctl,
   output logic [PSC_W-1:0]    psc_val,
   output logic                match,
   output logic                evt,
   output logic                irq
);
   logic [CNT_W-1:0] cnt_q, prd_q;
   logic             stat_q, invout_q, invin_q, cp_q, clksrc_q, tien_q;
   logic [1:0]       pwid_q, mode_q;
   logic [3:0]       pw_left_q;
   logic             tgl_q, irq_q;
   logic             active, go, step;

   assign active = tick & rel & (mode_q != MODE_OFF) & ~clksrc_q;

   generate
      if (HAS_PSC) begin : g_psc
         dt_prescale #(.PW(PSC_W)) u_psc (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (~rel),
            .load     (we_psc),
            .load_val (psc_wval),
            .adv      (active),
            .div      (psc_div),
            .cnt      (psc_val),
            .fire     (go)
         );
      end else begin : g_nopsc
         logic unused_psc;
         assign unused_psc = ^{we_psc, psc_wval, psc_div};
         assign go      = 1'b1;
         assign psc_val = '0;
      end
   endgenerate

   assign step  = active & go;
   assign match = step & (cnt_q == prd_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;  prd_q <= '0;
         stat_q <= 1'b0; invout_q <= 1'b0; invin_q <= 1'b0; cp_q <= 1'b0;
         pwid_q <= 2'b00; mode_q <= MODE_OFF; clksrc_q <= 1'b0; tien_q <= 1'b0;
         pw_left_q <= '0; tgl_q <= 1'b0; irq_q <= 1'b0;
      end else begin
         if (we_prd) prd_q <= wdata;

         if (!rel)        cnt_q <= '0;
         else if (we_cnt) cnt_q <= wdata;
         else if (match)  cnt_q <= '0;
         else if (step)   cnt_q <= cnt_q + 1'b1;

         if (we_ctl) begin
            stat_q   <= 1'b0;
            invout_q <= ctl_wdata[1];
            invin_q  <= ctl_wdata[2];
            cp_q     <= ctl_wdata[3];
            pwid_q   <= ctl_wdata[5:4];
            mode_q   <= ctl_wdata[7:6];
            clksrc_q <= ctl_wdata[8];
            tien_q   <= ctl_wdata[9];
         end else if (match && mode_q == MODE_ONCE) begin
            mode_q <= MODE_OFF;
            stat_q <= 1'b1;
         end

         if (match)                pw_left_q <= 4'd1 << pwid_q;
         else if (pw_left_q != '0) pw_left_q <= pw_left_q - 1'b1;

         if (!rel)       tgl_q <= 1'b0;
         else if (match) tgl_q <= ~tgl_q;

         irq_q <= match & tien_q;
      end
   end

   assign cnt = cnt_q;
   assign prd = prd_q;
   assign ctl = {tien_q, clksrc_q, mode_q, pwid_q, cp_q, invin_q, invout_q, stat_q};
   assign evt = (cp_q ? tgl_q : (pw_left_q != '0)) ^ invout_q;
   assign irq = irq_q;
endmodule

// File: rtl/dual_tmr32.sv
`timescale 1ns/1ps
module dual_tmr32
   import dt_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int ADDR_W  = 4,
   parameter int CLK_DIV = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              evt_lo,
   output logic              evt_hi,
   output logic              irq_lo,
   output logic              irq_hi
);
   localparam int NHALF = 2;

   generate
      if (CLK_DIV < 1 || CLK_DIV > 15) begin : g_bad_div
         $error("CLK_DIV must fit the 4-bit divisor field");
      end
      if (CNT_W < 8 || CNT_W > 32) begin : g_bad_w
         $error("CNT_W must be between 8 and 32");
      end
      if (ADDR_W < 4) begin : g_bad_a
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   logic                tick, we, we_ctl, we_gctl;
   logic [1:0]          rel_q, tmode_q;
   logic [PSC_W-1:0]    psc_div_q;
   logic [31:0]         wdt_q, rd_mux, rd_q;
   logic [CNT_W-1:0]    cnt_a [NHALF];
   logic [CNT_W-1:0]    prd_a [NHALF];
   logic [CTL_USED-1:0] ctl_a [NHALF];
   logic [PSC_W-1:0]    psc_a [NHALF];
   logic                match_a [NHALF];
   logic                evt_a [NHALF];
   logic                irq_a [NHALF];
   logic                we_cnt_a [NHALF];
   logic                we_prd_a [NHALF];

   assign we      = bus_sel & bus_wr;
   assign we_ctl  = we & (bus_addr == ADDR_W'(A_CTL));
   assign we_gctl = we & (bus_addr == ADDR_W'(A_GCTL));

   dt_tick #(.DIV(CLK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

   generate
      for (genvar i = 0; i < NHALF; i++) begin : g_half
         assign we_cnt_a[i] = we & (bus_addr == ADDR_W'(A_CNT_LO + i));
         assign we_prd_a[i] = we & (bus_addr == ADDR_W'(A_PRD_LO + i));
         dt_half #(.CNT_W(CNT_W), .HAS_PSC(i == 1)) u_half (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .rel       (rel_q[i]),
            .we_cnt    (we_cnt_a[i]),
            .we_prd    (we_prd_a[i]),
            .we_ctl    (we_ctl),
            .wdata     (bus_wdata[CNT_W-1:0]),
            .ctl_wdata (bus_wdata[i*CTL_STRIDE +: CTL_USED]),
            .we_psc    (we_gctl),
            .psc_wval  (bus_wdata[11:8]),
            .psc_div   (psc_div_q),
            .cnt       (cnt_a[i]),
            .prd       (prd_a[i]),
            .ctl       (ctl_a[i]),
            .psc_val   (psc_a[i]),
            .match     (match_a[i]),
            .evt       (evt_a[i]),
            .irq       (irq_a[i])
         );
      end
   endgenerate

   logic unused_bits;
   assign unused_bits = ^{psc_a[0], match_a[1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_q <= '0; tmode_q <= '0; psc_div_q <= '0; wdt_q <= '0;
      end else begin
         if (we_gctl) begin
            rel_q     <= bus_wdata[1:0];
            tmode_q   <= bus_wdata[3:2];
            psc_div_q <= bus_wdata[15:12];
         end
         if (we && bus_addr == ADDR_W'(A_WDT)) wdt_q <= bus_wdata;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (bus_addr)
         ADDR_W'(A_CLKSPD): rd_mux = {12'b0, 4'(CLK_DIV), 16'b0};
         ADDR_W'(A_CNT_LO): rd_mux = 32'(cnt_a[0]);
         ADDR_W'(A_CNT_HI): rd_mux = 32'(cnt_a[1]);
         ADDR_W'(A_PRD_LO): rd_mux = 32'(prd_a[0]);
         ADDR_W'(A_PRD_HI): rd_mux = 32'(prd_a[1]);
         ADDR_W'(A_CTL):    rd_mux = {6'b0, ctl_a[1], 6'b0, ctl_a[0]};
         ADDR_W'(A_GCTL):   rd_mux = {16'b0, psc_div_q, psc_a[1], 4'b0, tmode_q, rel_q};
         ADDR_W'(A_WDT):    rd_mux = wdt_q;
         default:           rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 rd_q <= '0;
      else if (bus_sel && !bus_wr) rd_q <= rd_mux;
   end

   assign bus_rdata = rd_q;
   assign evt_lo    = evt_a[0];
   assign evt_hi    = evt_a[1];
   assign irq_lo    = irq_a[0];
   assign irq_hi    = irq_a[1];

   // named views for the bound checker
   logic [CNT_W-1:0] chk_cnt_lo, chk_cnt_hi;
   logic [1:0]       chk_mode_lo;
   logic             chk_stat_lo, chk_tien_lo, chk_match_lo;
   assign chk_cnt_lo   = cnt_a[0];
   assign chk_cnt_hi   = cnt_a[1];
   assign chk_mode_lo  = ctl_a[0][7:6];
   assign chk_stat_lo  = ctl_a[0][0];
   assign chk_tien_lo  = ctl_a[0][9];
   assign chk_match_lo = match_a[0];
endmodule

// File: rtl/dt_chk.sv
`timescale 1ns/1ps
module dt_chk #(
   parameter int CNT_W   = 32,
   parameter int ADDR_W  = 4,
   parameter int CLK_DIV = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_rdata,
   input logic [1:0]        rel,
   input logic [CNT_W-1:0]  cnt_lo,
   input logic [CNT_W-1:0]  cnt_hi,
   input logic [1:0]        mode_lo,
   input logic              stat_lo,
   input logic              tien_lo,
   input logic              match_lo,
   input logic              we_ctl,
   input logic              we_cnt_lo,
   input logic              we_cnt_hi,
   input logic [3:0]        psc_hi,
   input logic              irq_lo
);
   assert_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rel[0] |=> cnt_lo == '0)
      else $error("low half left zero while held");

   assert_stop_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_lo == 2'b00 && rel[0] && !we_cnt_lo) |=> $stable(cnt_lo))
      else $error("stopped low half changed count");

   assert_oneshot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (match_lo && mode_lo == 2'b01 && !we_ctl) |=> (mode_lo == 2'b00 && stat_lo))
      else $error("one-shot did not stop itself");

   assert_irq_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_lo |-> $past(tien_lo))
      else $error("interrupt without enable");

   assert_psc_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rel[1] && !we_cnt_hi && psc_hi != 4'd0) |=> $stable(cnt_hi))
      else $error("high half counted with prescaler nonzero");

   assert_clkspd_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == ADDR_W'(1)) |=> bus_rdata == {12'b0, 4'(CLK_DIV), 16'b0})
      else $error("clock-speed word wrong");
endmodule

bind dual_tmr32 dt_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .CLK_DIV(CLK_DIV)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .rel       (rel_q),
   .cnt_lo    (chk_cnt_lo),
   .cnt_hi    (chk_cnt_hi),
   .mode_lo   (chk_mode_lo),
   .stat_lo   (chk_stat_lo),
   .tien_lo   (chk_tien_lo),
   .match_lo  (chk_match_lo),
   .we_ctl    (we_ctl),
   .we_cnt_lo (we_cnt_a[0]),
   .we_cnt_hi (we_cnt_a[1]),
   .psc_hi    (psc_a[1]),
   .irq_lo    (irq_lo)
);

// File: tb/dual_tmr32_bench.sv
`timescale 1ns/1ps
module dual_tmr32_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, wr = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        evt_lo, evt_hi, irq_lo, irq_hi;
   int          n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   dual_tmr32 u_dual_tmr32 (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .evt_lo(evt_lo), .evt_hi(evt_hi),
      .irq_lo(irq_lo), .irq_hi(irq_hi)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // commit happens on the posedge between the two negedges
   task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); sel = 1'b0; wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
      @(negedge clk); sel = 1'b0; d = rdata;
   endtask

   task automatic stop_lo();
      wr_reg(4'd8, 32'h0);
      wr_reg(4'd4, 32'h0);
      repeat (12) @(negedge clk);
   endtask

   // cycles between two consecutive samples where sig goes to level 1
   task automatic gap_irq(output int n);
      n = 0;
      for (int k = 0; k < 100 && !irq_lo; k++) @(negedge clk);
      @(negedge clk); n = 1;
      for (int k = 0; k < 100 && !irq_lo; k++) begin @(negedge clk); n++; end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 reset evt/irq", {28'b0, evt_lo, evt_hi, irq_lo, irq_hi}, 32'h0);
      rd_reg(4'd4, d);  chk("R1 reset count lo", d, 32'h0);
      rd_reg(4'd8, d);  chk("R1 reset control", d, 32'h0);
      rd_reg(4'd0, d);  chk("R1 reserved index 0", d, 32'h0);
      rd_reg(4'd1, d);  chk("R1 clock-speed divisor", d, 32'h0001_0000);
      wr_reg(4'd1, 32'hFFFF_FFFF);
      rd_reg(4'd1, d);  chk("R1 clock-speed ignores write", d, 32'h0001_0000);
   endtask

   task automatic t_release();
      logic [31:0] d;
      wr_reg(4'd6, 32'd5);
      wr_reg(4'd8, 32'h0000_0080);
      repeat (10) @(negedge clk);
      rd_reg(4'd4, d); chk("R2 held half stays zero", d, 32'h0);
      wr_reg(4'd4, 32'h55);
      rd_reg(4'd4, d); chk("R2 count write ignored while held", d, 32'h0);
      wr_reg(4'd8, 32'h0);
   endtask

   task automatic t_period();
      int n;
      stop_lo();
      wr_reg(4'd6, 32'd3);
      wr_reg(4'd8, 32'h0000_0280);
      gap_irq(n);
      chk("R4 R11 match spacing prd=3", n, 4);
      chk("R8 evt pulse with irq", {31'b0, evt_lo}, 32'h1);
      @(negedge clk);
      chk("R7 irq is one cycle", {31'b0, irq_lo}, 32'h0);
      wr_reg(4'd6, 32'd6);
      gap_irq(n); gap_irq(n);
      chk("R4 match spacing prd=6", n, 7);
   endtask

   task automatic t_pulse();
      int n;
      stop_lo();
      wr_reg(4'd6, 32'd19);
      wr_reg(4'd8, 32'h0000_00A0);
      for (int k = 0; k < 100 && !evt_lo; k++) @(negedge clk);
      n = 0;
      for (int k = 0; k < 100 && evt_lo; k++) begin n++; @(negedge clk); end
      chk("R8 pulse width 2^2", n, 4);
   endtask

   task automatic t_toggle();
      int n;
      logic lv;
      stop_lo();
      wr_reg(4'd6, 32'd3);
      wr_reg(4'd8, 32'h0000_0088);
      lv = evt_lo;
      for (int k = 0; k < 100 && evt_lo == lv; k++) @(negedge clk);
      lv = evt_lo; n = 0;
      for (int k = 0; k < 100 && evt_lo == lv; k++) begin n++; @(negedge clk); end
      chk("R8 toggle spacing", n, 4);
   endtask

   task automatic t_invert();
      stop_lo();
      wr_reg(4'd8, 32'h0000_0002);
      chk("R8 inverted idle level", {31'b0, evt_lo}, 32'h1);
      wr_reg(4'd8, 32'h0);
      chk("R8 normal idle level", {31'b0, evt_lo}, 32'h0);
   endtask

   task automatic t_stop_keep();
      logic [31:0] a, b;
      stop_lo();
      wr_reg(4'd6, 32'hFFFF_FFFF);
      wr_reg(4'd8, 32'h0000_0080);
      repeat (20) @(negedge clk);
      wr_reg(4'd8, 32'h0);
      rd_reg(4'd4, a);
      repeat (5) @(negedge clk);
      rd_reg(4'd4, b);
      chk("R3 stop keeps count", b, a);
      chk("R3 count had advanced", {31'b0, a != 0}, 32'h1);
   endtask

   task automatic t_cnt_write();
      logic [31:0] d;
      wr_reg(4'd4, 32'h0000_1234);
      rd_reg(4'd4, d); chk("R6 count load while stopped", d, 32'h1234);
      wr_reg(4'd8, 32'h0000_0080);
      wr_reg(4'd4, 32'h0000_2000);
      // load at edge E, one count at E+1, read captured at E+2
      rd_reg(4'd4, d); chk("R6 count load while running", d, 32'h2001);
      wr_reg(4'd8, 32'h0);
   endtask

   task automatic t_oneshot();
      logic [31:0] d;
      int n;
      stop_lo();
      wr_reg(4'd6, 32'd4);
      wr_reg(4'd8, 32'h0000_0240);
      n = 0;
      for (int k = 0; k < 30; k++) begin @(negedge clk); if (irq_lo) n++; end
      chk("R5 R7 one-shot fires once", n, 1);
      rd_reg(4'd8, d); chk("R5 mode cleared, status set", d, 32'h0000_0201);
      rd_reg(4'd4, d); chk("R5 count back at zero", d, 32'h0);
      wr_reg(4'd8, 32'h0000_0200);
      rd_reg(4'd8, d); chk("R5 control write clears status", d, 32'h0000_0200);
   endtask

   task automatic t_clksrc();
      logic [31:0] d;
      stop_lo();
      wr_reg(4'd6, 32'd100);
      wr_reg(4'd8, 32'h0000_0180);
      repeat (10) @(negedge clk);
      rd_reg(4'd4, d); chk("R10 clock-source set, no counting", d, 32'h0);
      wr_reg(4'd8, 32'h0);
   endtask

   task automatic t_prescale();
      logic [31:0] d;
      wr_reg(4'd9, 32'h0000_2007);
      wr_reg(4'd5, 32'h0);
      wr_reg(4'd7, 32'h0000_FFFF);
      wr_reg(4'd8, 32'h0080_0000);
      // active edges E1..E31, counts on edges 1,4,...,31
      repeat (30) @(posedge clk);
      wr_reg(4'd8, 32'h0);
      rd_reg(4'd5, d); chk("R9 high half count with div 2", d, 32'd11);
      rd_reg(4'd9, d); chk("R9 prescale counter visible", d, 32'h0000_2207);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      wr_reg(4'd10, 32'hA5A5_0001);
      rd_reg(4'd10, d); chk("R12 watchdog word stored", d, 32'hA5A5_0001);
      wr_reg(4'd9, 32'h0000_200F);
      rd_reg(4'd9, d); chk("R12 timer-mode field stored", d, 32'h0000_200F);
      rd_reg(4'd2, d); chk("R1 reserved index 2", d, 32'h0);
      stop_lo();
      wr_reg(4'd6, 32'd3);
      wr_reg(4'd8, 32'h0000_0280);
      begin
         int n;
         gap_irq(n);
         chk("R12 mode field leaves counting alone", n, 4);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_release();
      wr_reg(4'd9, 32'h0000_0005);
      t_period();
      t_pulse();
      t_toggle();
      t_invert();
      t_stop_keep();
      t_cnt_write();
      t_oneshot();
      t_clksrc();
      t_prescale();
      t_regs();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule